// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and main memory and holds stores that are waiting to be written out. Every slot is one memory-path line wide: a block address, several word-sized lanes and one valid flag per lane. When a store arrives, its block address is compared against every live slot that is still open for merging. On a match, the word goes into that slot: it overwrites whatever that lane held and sets the lane's flag. Only when nothing matches does the store claim a fresh slot. Several single-word stores to one block therefore leave the block as a single wide memory write.

Slots leave in the order they were claimed. The oldest slot is offered on the memory port together with its block address, all of its lanes and its lane mask, in one transfer that is held until memory accepts it. From the moment a slot is offered it is closed to merges. A later store to the same block opens a new, younger slot. This keeps the order in which data reaches memory correct.

A read-check port lets a load look in the buffer before the older buffered writes reach memory. If any slot holds a valid copy of the requested word, the word comes straight back. If more than one slot holds it, the copy from the youngest slot is returned.

Top module: `merge_wbuf`

## Requirements
- R1: After synchronous reset the buffer is empty: `mem_valid` is 0, `st_ready` is 1 and `rd_hit` is 0.
- R2: The store address is `{block, word index}`, where the low `$clog2(WORDS)` bits pick the lane. If an accepted store matches no open slot, it claims a new slot at the young end. That slot has only the stored lane's mask bit set.
- R3: If an accepted store's block equals that of a live slot open for merging, the slot's lane takes the new data and its mask bit is set. A lane that already held data is overwritten, and no new slot is claimed.
- R4: `st_ready` is 0 only when no open slot matches the store and all ENTRIES slots are live. A store offered while `st_ready` is 0 changes no slot.
- R5: `mem_valid` is 1 exactly when at least one slot is live. It presents the oldest slot's block on `mem_blk`, its mask on `mem_mask` (bit i = lane i) and lane i on `mem_data[i*WORD_W +: WORD_W]`. These are held unchanged until `mem_ready`.
- R6: The slot being presented on the memory port accepts no merge. A store to its block claims a new slot.
- R7: A transfer completes when `mem_valid` and `mem_ready` are both 1 at a clock edge. That slot is then freed, and the next-oldest slot is presented on the following cycle.
- R8: When `rd_valid` is 1, `rd_hit` is 1 if some live slot holds the addressed block with that lane's mask bit set. `rd_data` is then the lane from the youngest such slot. Otherwise `rd_hit` is 0 and `rd_data` is 0.
- R9: The read check sees the buffer as it stood at the start of the cycle. A store to the same word in the same cycle does not show up until the next cycle.
- R10: A store and a completed transfer in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_addr | input | BLK_W+WIDX_W | Store word address {block, lane} |
| st_data | input | WORD_W | Store data |
| st_ready | output | 1 | Store can be taken this cycle |
| rd_valid | input | 1 | Read-check request |
| rd_addr | input | BLK_W+WIDX_W | Read-check word address {block, lane} |
| rd_hit | output | 1 | Buffered copy of the word exists |
| rd_data | output | WORD_W | Youngest buffered copy, 0 on miss |
| mem_valid | output | 1 | A line is offered to memory |
| mem_ready | input | 1 | Memory takes the offered line |
| mem_blk | output | BLK_W | Block address of the offered line |
| mem_data | output | WORDS*WORD_W | All lanes of the offered line |
| mem_mask | output | WORDS | Per-lane valid mask of the offered line |

## Verification
Two cases can land in the same cycle. In the first, a store and a completed memory transfer coincide: the store merges into or claims a slot while the oldest slot leaves. In the second, a read check and a store target the same word, so the read has to return the older copy or a miss. The bench provokes both on purpose, first in directed sequences with memory held off and then released, and later under random traffic drawn from a small pool of blocks with a busy/idle pattern on `mem_ready` that shifts over time. A queue-style reference model steps along on every clock and predicts `st_ready`, the offered line and the read result. Each mismatch is reported with the requirement that the current situation exercises.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    parameter int WORD_W  = 32;
    parameter int WORDS   = 4;
    parameter int ENTRIES = 4;
    parameter int BLK_W   = 14;

    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W  = $clog2(ENTRIES + 1);
    localparam int ADDR_W = BLK_W + WIDX_W;
    localparam int LINE_W = WORD_W * WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [WORDS-1:0]  mask_t;
    typedef logic [WIDX_W-1:0] widx_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic                         live;
        blk_t                         blk;
        mask_t                        mask;
        logic [WORDS-1:0][WORD_W-1:0] lanes;
    } line_t;

    function automatic mask_t lane_bit(input widx_t i);
        return mask_t'(1) << i;
    endfunction

    function automatic ptr_t ptr_next(input ptr_t p);
        return (int'(p) == ENTRIES - 1) ? ptr_t'(0) : ptr_t'(p + ptr_t'(1));
    endfunction

    function automatic ptr_t ptr_age(input ptr_t head, input int k);
        return ptr_t'((int'(head) + k) % ENTRIES);
    endfunction

endpackage

// File: rtl/mwb_ring.sv
module mwb_ring
    import mwb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    output ptr_t head,
    output ptr_t tail,
    output cnt_t count,
    output logic full,
    output logic empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= ptr_next(tail);
            if (pop)  head <= ptr_next(head);
            count <= count + cnt_t'(push) - cnt_t'(pop);
        end
    end

    assign full  = (int'(count) == ENTRIES);
    assign empty = (count == '0);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R10
    count_track_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(count));

endmodule

// File: rtl/mwb_lookup.sv
module mwb_lookup
    import mwb_pkg::*;
(
    input  line_t               lines [ENTRIES],
    input  ptr_t                head,
    input  cnt_t                count,
    input  blk_t                st_blk,
    input  logic                rd_valid,
    input  blk_t                rd_blk,
    input  widx_t               rd_idx,
    output logic [ENTRIES-1:0]  merge_sel,
    output logic                merge_hit,
    output logic                rd_hit,
    output word_t               rd_data
);

    // Merge candidates: live, matching block, and not the slot on the memory port.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic on_port;
        assign on_port      = (head == ptr_t'(g)) && (count != '0);
        assign merge_sel[g] = lines[g].live && !on_port && (lines[g].blk == st_blk);
    end

    assign merge_hit = |merge_sel;

    // Read check: walk oldest to youngest, the last hit wins.
    always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            ptr_t p;
            p = ptr_age(head, k);
            if (rd_valid && (k < int'(count)) && lines[p].live &&
                (lines[p].blk == rd_blk) && lines[p].mask[rd_idx]) begin
                rd_hit  = 1'b1;
                rd_data = lines[p].lanes[rd_idx];
            end
        end
    end

endmodule

// File: rtl/mwb_lines.sv
module mwb_lines
    import mwb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc,
    input  logic               merge,
    input  logic [ENTRIES-1:0] merge_sel,
    input  logic               pop,
    input  ptr_t               head,
    input  ptr_t               tail,
    input  blk_t               st_blk,
    input  widx_t              st_idx,
    input  word_t              st_data,
    output line_t              lines [ENTRIES]
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                lines[g] <= '0;
            end else begin
                if (alloc && (tail == ptr_t'(g))) begin
                    lines[g].live  <= 1'b1;
                    lines[g].blk   <= st_blk;
                    lines[g].mask  <= lane_bit(st_idx);
                    lines[g].lanes <= '0;
                    lines[g].lanes[st_idx] <= st_data;
                end else if (merge && merge_sel[g]) begin
                    lines[g].mask <= lines[g].mask | lane_bit(st_idx);
                    lines[g].lanes[st_idx] <= st_data;
                end else if (pop && (head == ptr_t'(g))) begin
                    lines[g].live <= 1'b0;
                    lines[g].mask <= '0;
                end
            end
        end

        // R3
        merge_keeps_block_chk: assert property (@(posedge clk) disable iff (rst)
            (merge && merge_sel[g]) |=> (lines[g].live && $stable(lines[g].blk)));
    end

    // R3
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(merge_sel));

    // R6
    no_merge_on_head_chk: assert property (@(posedge clk) disable iff (rst)
        (merge && lines[head].live) |-> !merge_sel[head]);

endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import mwb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    st_valid,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [WORD_W-1:0]       st_data,
    output logic                    st_ready,
    input  logic                    rd_valid,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_hit,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [BLK_W-1:0]        mem_blk,
    output logic [LINE_W-1:0]       mem_data,
    output logic [WORDS-1:0]        mem_mask
);

    line_t              lines [ENTRIES];
    ptr_t               head;
    ptr_t               tail;
    cnt_t               count;
    logic               full;
    logic               empty;
    logic [ENTRIES-1:0] merge_sel;
    logic               merge_hit;
    logic               push;
    logic               merge;
    logic               pop;
    blk_t               st_blk;
    widx_t              st_idx;
    blk_t               rd_blk;
    widx_t              rd_idx;

    assign st_blk = st_addr[ADDR_W-1:WIDX_W];
    assign st_idx = st_addr[WIDX_W-1:0];
    assign rd_blk = rd_addr[ADDR_W-1:WIDX_W];
    assign rd_idx = rd_addr[WIDX_W-1:0];

    assign st_ready = merge_hit || !full;
    assign merge    = st_valid && merge_hit;
    assign push     = st_valid && !merge_hit && !full;
    assign mem_valid = !empty;
    assign pop      = mem_valid && mem_ready;

    mwb_ring i_ring (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .head  (head),
        .tail  (tail),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    mwb_lookup i_lookup (
        .lines     (lines),
        .head      (head),
        .count     (count),
        .st_blk    (st_blk),
        .rd_valid  (rd_valid),
        .rd_blk    (rd_blk),
        .rd_idx    (rd_idx),
        .merge_sel (merge_sel),
        .merge_hit (merge_hit),
        .rd_hit    (rd_hit),
        .rd_data   (rd_data)
    );

    mwb_lines i_lines (
        .clk       (clk),
        .rst       (rst),
        .alloc     (push),
        .merge     (merge),
        .merge_sel (merge_sel),
        .pop       (pop),
        .head      (head),
        .tail      (tail),
        .st_blk    (st_blk),
        .st_idx    (st_idx),
        .st_data   (st_data),
        .lines     (lines)
    );

    assign mem_blk  = lines[head].blk;
    assign mem_mask = lines[head].mask;
    assign mem_data = lines[head].lanes;

    // R5
    hold_offer_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_blk) &&
                                       $stable(mem_mask) && $stable(mem_data)));

    // R4
    reject_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready && !pop) |=> $stable(count));

    // R5
    offer_has_lane_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_mask != '0));

    // R8
    hit_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (rd_valid && mem_valid));

    // R7
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (count == $past(count) - cnt_t'(1)));

endmodule

// File: tb/test_merge_wbuf.sv
module test_merge_wbuf;
    import mwb_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              rst;
    logic              st_valid;
    logic [ADDR_W-1:0] st_addr;
    logic [WORD_W-1:0] st_data;
    logic              st_ready;
    logic              rd_valid;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_hit;
    logic [WORD_W-1:0] rd_data;
    logic              mem_valid;
    logic              mem_ready;
    logic [BLK_W-1:0]  mem_blk;
    logic [LINE_W-1:0] mem_data;
    logic [WORDS-1:0]  mem_mask;

    merge_wbuf i_merge_wbuf (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_blk(mem_blk),
        .mem_data(mem_data), .mem_mask(mem_mask)
    );

    // Reference model: index 0 is the oldest pending line.
    int                m_cnt;
    int                m_blk [ENTRIES];
    logic [WORD_W-1:0] m_dat [ENTRIES][WORDS];
    logic [WORDS-1:0]  m_msk [ENTRIES];

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string force_tag = "";
    bit    last_pop = 0;
    bit    last_both = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        string t;
        t = (force_tag != "") ? force_tag : tag;
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    function automatic int find_open(input int b);
        for (int j = 1; j < m_cnt; j++) if (m_blk[j] == b) return j;
        return -1;
    endfunction

    task automatic cycle(input bit sv, input int sb, input int si, input logic [WORD_W-1:0] sd,
                         input bit rv, input int rb, input int ri, input bit mr);
        bit                exp_rdy, exp_mv, exp_hit, take, popx;
        logic [WORD_W-1:0] exp_rd;
        logic [LINE_W-1:0] exp_line, act_line, lane_en;
        int                tgt;
        @(negedge clk);
        st_valid  = sv;
        st_addr   = {BLK_W'(sb), WIDX_W'(si)};
        st_data   = sd;
        rd_valid  = rv;
        rd_addr   = {BLK_W'(rb), WIDX_W'(ri)};
        mem_ready = mr;
        #1;
        tgt     = find_open(sb);
        exp_rdy = (tgt >= 0) || (m_cnt < ENTRIES);
        exp_mv  = (m_cnt > 0);
        chk(st_ready == exp_rdy, "R4", LINE_W'(st_ready), LINE_W'(exp_rdy));
        chk(mem_valid == exp_mv, last_both ? "R10" : (last_pop ? "R7" : "R5"),
            LINE_W'(mem_valid), LINE_W'(exp_mv));
        if (exp_mv) begin
            chk(mem_blk == BLK_W'(m_blk[0]), last_pop ? "R7" : "R5",
                LINE_W'(mem_blk), LINE_W'(m_blk[0]));
            chk(mem_mask == m_msk[0], "R5", LINE_W'(mem_mask), LINE_W'(m_msk[0]));
            exp_line = '0;
            lane_en  = '0;
            for (int w = 0; w < WORDS; w++) begin
                if (m_msk[0][w]) begin
                    exp_line[w*WORD_W +: WORD_W] = m_dat[0][w];
                    lane_en[w*WORD_W +: WORD_W]  = '1;
                end
            end
            act_line = mem_data & lane_en;
            chk(act_line == exp_line, "R5", act_line, exp_line);
        end
        exp_hit = 0;
        exp_rd  = '0;
        if (rv) begin
            for (int j = 0; j < m_cnt; j++) begin
                if (m_blk[j] == rb && m_msk[j][ri]) begin
                    exp_hit = 1;
                    exp_rd  = m_dat[j][ri];
                end
            end
        end
        chk(rd_hit == exp_hit, (sv && rv && sb == rb && si == ri) ? "R9" : "R8",
            LINE_W'(rd_hit), LINE_W'(exp_hit));
        chk(rd_data == exp_rd, "R8", LINE_W'(rd_data), LINE_W'(exp_rd));

        @(posedge clk);
        take = sv && exp_rdy;
        popx = exp_mv && mr;
        if (take) begin
            if (tgt >= 0) begin
                m_dat[tgt][si] = sd;
                m_msk[tgt][si] = 1'b1;
            end else begin
                m_blk[m_cnt] = sb;
                m_msk[m_cnt] = '0;
                m_msk[m_cnt][si] = 1'b1;
                m_dat[m_cnt][si] = sd;
                m_cnt++;
            end
        end
        if (popx) begin
            for (int j = 0; j < ENTRIES - 1; j++) begin
                m_blk[j] = m_blk[j+1];
                m_msk[j] = m_msk[j+1];
                for (int w = 0; w < WORDS; w++) m_dat[j][w] = m_dat[j+1][w];
            end
            m_cnt--;
        end
        last_pop  = popx;
        last_both = popx && take;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_cnt = 0;
        rst = 1; st_valid = 0; st_addr = '0; st_data = '0;
        rd_valid = 0; rd_addr = '0; mem_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        rd_valid = 1;
        #1;
        chk(mem_valid == 0, "R1", LINE_W'(mem_valid), '0);
        chk(st_ready == 1, "R1", LINE_W'(st_ready), LINE_W'(1));
        chk(rd_hit == 0, "R1", LINE_W'(rd_hit), '0);

        // New line with a single lane, read of that word in the same cycle misses
        force_tag = "R2";
        cycle(1, 1, 0, 32'hA0, 1, 1, 0, 0);
        cycle(0, 0, 0, 0, 1, 1, 0, 0);
        // Head is on the memory port: same block opens a new line
        force_tag = "R6";
        cycle(1, 1, 2, 32'hB2, 1, 1, 2, 0);
        cycle(0, 0, 0, 0, 1, 1, 2, 0);
        // Merge into the younger line, then overwrite a lane
        force_tag = "R3";
        cycle(1, 1, 3, 32'hB3, 1, 1, 0, 0);
        cycle(1, 1, 2, 32'hC2, 1, 1, 3, 0);
        cycle(0, 0, 0, 0, 1, 1, 2, 0);
        // Fill the buffer, then a new block is refused
        force_tag = "R4";
        cycle(1, 2, 1, 32'hD1, 0, 0, 0, 0);
        cycle(1, 3, 0, 32'hE0, 0, 0, 0, 0);
        cycle(1, 4, 0, 32'hF0, 1, 4, 0, 0);
        cycle(1, 3, 3, 32'hE3, 1, 3, 3, 0);
        // Release memory: drain while merging and allocating
        force_tag = "R10";
        cycle(1, 4, 1, 32'h41, 1, 1, 0, 1);
        cycle(1, 4, 1, 32'h41, 1, 1, 2, 1);
        cycle(1, 2, 2, 32'h22, 1, 4, 1, 1);
        force_tag = "R7";
        for (int n = 0; n < 6; n++) cycle(0, 0, 0, 0, 1, 2, 2, 1);
        force_tag = "";

        // Random traffic over a small block pool
        for (int n = 0; n < 6000; n++) begin
            int ph;
            bit mr;
            ph = (n / 150) % 3;
            mr = (ph == 0) ? ($urandom_range(0, 9) < 2) :
                 (ph == 1) ? ($urandom_range(0, 9) < 6) : 1'b1;
            cycle($urandom_range(0, 3) != 0, $urandom_range(0, 5), $urandom_range(0, WORDS - 1),
                  $urandom, $urandom_range(0, 1), $urandom_range(0, 5),
                  $urandom_range(0, WORDS - 1), mr);
        end
        finish_run();
    end

endmodule